// File: doc/BRIEF.md
# Interrupt Flag and Status Register Pair

This block collects three event sources (periodic tick, alarm match and update-ended) into sticky flags, gates them with enable bits held in a control byte, and drives an active-low, open-drain interrupt request line. The line is modelled here as an output-enable that is high while the line must be pulled low. A host reaches the block through a small register port. It writes the control byte, reads the status byte to learn which sources fired, and reads a constant valid-data byte.

A status read is a two-phase operation. The value returned is captured on the first cycle of the read strobe. The flags clear when the strobe drops. Any event that arrives while the strobe is high is not lost: it is parked and posted into the flags in the cycle the read ends. The events themselves come from elsewhere. Each event input is a one-cycle pulse in the block's clock domain.

Register select (`reg_sel`) encodings: 0 = control byte, 1 = status byte, 2 = valid-data byte, 3 = unused (reads 0x00, writes ignored).

Top module: `irq_status_regs`

## Requirements
- R1: The status byte returns the request summary in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update flag in bit 4. Bits 3 to 0 always read 0.
- R2: `irq_oe` is 1 exactly when at least one flag is set together with its enable. The enables are control bit 6 (periodic), bit 5 (alarm) and bit 4 (update). The summary bit 7 of the status byte equals this value.
- R3: The control byte reads back as written. Its bits are 7 freeze, 6 to 4 the enables, 3 square-wave on, 2 binary mode, 1 24-hour, 0 daylight-saving. The only exception is the rule in R8.
- R4: An event pulse sets its flag whether or not its enable bit is 1.
- R5: A status read returns the flags as they stood on the first strobe cycle. All flags and the summary are cleared when the strobe ends.
- R6: An event that arrives on any cycle of a status read, including the first and the ending cycle, shows up as a set flag after the read ends.
- R7: Writing an enable to 1 while its flag is already set raises `irq_oe` in the next cycle.
- R8: A control write with bit 7 (freeze) equal to 1 stores 0 in the update enable (bit 4), whatever value was written to bit 4.
- R9: The valid-data byte always reads 0x80. Writes to the valid-data, status or unused selects change nothing.
- R10: After reset the control byte and all flags are 0 and `irq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select, sampled on write and on the first read-strobe cycle |
| wr_en | input | 1 | Write strobe, one write per cycle high |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Read strobe: data is captured on its first cycle and the read ends when it falls |
| rd_data | output | 8 | Registered read data, valid from the cycle after the strobe rises |
| ev_periodic | input | 1 | Periodic event pulse |
| ev_alarm | input | 1 | Alarm event pulse |
| ev_update | input | 1 | Update-ended event pulse |
| irq_oe | output | 1 | High while the open-drain request line must be pulled low |

## Verification
A flag that is set when it should not be shows as a spurious `irq_oe` in the cycle after its enable is written. It also shows as an extra bit in the next status read. A flag lost during a read shows only on the read that follows, because the held event is posted when the strobe falls. The bench therefore reads the status byte again after every read that carried an event. The freeze rule on the update enable appears on the next control readback.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int BYTE_W  = 8;
    localparam int NUM_SRC = 3;
    localparam int ADDR_W  = 2;
    localparam int PAD_W   = BYTE_W - 1 - NUM_SRC;

    // source indices, also the offset of each enable above bit 3
    localparam int UPD_IDX = 0;
    localparam int ALM_IDX = 1;
    localparam int PER_IDX = 2;

    localparam logic [BYTE_W-1:0] VALID_BYTE = {1'b1, {(BYTE_W-1){1'b0}}};

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_VALID = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic               freeze;
        logic [NUM_SRC-1:0] en;
        logic               sqw_on;
        logic               bin_mode;
        logic               hr24;
        logic               dst_on;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] status_byte(
        input logic               req,
        input logic [NUM_SRC-1:0] flags
    );
        return {req, flags, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
    import irq_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_stb,
    input  ctrl_t wr_val,
    output ctrl_t ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_stb) begin
            ctrl_q <= wr_val;
            if (wr_val.freeze) begin
                ctrl_q.en[UPD_IDX] <= 1'b0;
            end
        end
    end

    // R8: freeze written high leaves update enable low
    a_r8_freeze_drops_upd: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_val.freeze) |=> !ctrl_q.en[UPD_IDX]);

    // R3: a plain write is stored unchanged
    a_r3_write_stored: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !wr_val.freeze) |=> (ctrl_q == $past(wr_val)));
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_status_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic         in_read,
    input  logic         end_read,
    output logic [N-1:0] flags
);
    logic [N-1:0] held;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
                held[i]  <= 1'b0;
            end else if (end_read) begin
                flags[i] <= held[i] | ev[i];
                held[i]  <= 1'b0;
            end else if (in_read) begin
                held[i]  <= held[i] | ev[i];
            end else begin
                flags[i] <= flags[i] | ev[i];
            end
        end

        // R4: an event outside a read sets its flag
        a_r4_event_sets: assert property (@(posedge clk) disable iff (rst)
            (ev[i] && !in_read && !end_read) |=> flags[i]);

        // R5: a read end with nothing pending leaves the flag clear
        a_r5_clear_at_end: assert property (@(posedge clk) disable iff (rst)
            (end_read && !ev[i] && !held[i]) |=> !flags[i]);

        // R6: an event at the read end is posted
        a_r6_end_event_posted: assert property (@(posedge clk) disable iff (rst)
            (end_read && ev[i]) |=> flags[i]);

        // R5: flags are frozen while the read is open
        a_r5_frozen_in_read: assert property (@(posedge clk) disable iff (rst)
            (in_read && !end_read) |=> $stable(flags[i]));
    end
endmodule

// File: rtl/irq_readback.sv
module irq_readback
    import irq_status_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  reg_sel_e           sel,
    input  ctrl_t              ctrl,
    input  logic [NUM_SRC-1:0] flags,
    input  logic               req,
    output logic [BYTE_W-1:0]  rd_q
);
    logic [BYTE_W-1:0] mux_val;

    always_comb begin
        unique case (sel)
            SEL_CTRL:  mux_val = ctrl;
            SEL_STAT:  mux_val = status_byte(req, flags);
            SEL_VALID: mux_val = VALID_BYTE;
            default:   mux_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (capture) begin
            rd_q <= mux_val;
        end
    end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
    import irq_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_sel,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ev_periodic,
    input  logic              ev_alarm,
    input  logic              ev_update,
    output logic              irq_oe
);
    reg_sel_e           sel;
    ctrl_t              ctrl;
    logic [NUM_SRC-1:0] ev_vec;
    logic [NUM_SRC-1:0] flags;
    logic               rd_q;
    logic               stat_tgt_q;
    logic               rd_rise;
    logic               in_read;
    logic               end_read;
    logic               req;
    logic               wr_ctrl;

    assign sel     = reg_sel_e'(reg_sel);
    assign wr_ctrl = wr_en && (sel == SEL_CTRL);

    always_comb begin
        ev_vec          = '0;
        ev_vec[PER_IDX] = ev_periodic;
        ev_vec[ALM_IDX] = ev_alarm;
        ev_vec[UPD_IDX] = ev_update;
    end

    // read phase tracking: open on the rising strobe, close on its fall
    assign rd_rise  = rd_stb && !rd_q;
    assign in_read  = rd_stb && (rd_rise ? (sel == SEL_STAT) : stat_tgt_q);
    assign end_read = !rd_stb && rd_q && stat_tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q       <= 1'b0;
            stat_tgt_q <= 1'b0;
        end else begin
            rd_q <= rd_stb;
            if (rd_rise) begin
                stat_tgt_q <= (sel == SEL_STAT);
            end else if (!rd_stb) begin
                stat_tgt_q <= 1'b0;
            end
        end
    end

    irq_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_ctrl),
        .wr_val (ctrl_t'(wr_data)),
        .ctrl_q (ctrl)
    );

    irq_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev_vec),
        .in_read  (in_read),
        .end_read (end_read),
        .flags    (flags)
    );

    assign req    = |(flags & ctrl.en);
    assign irq_oe = req;

    irq_readback u_rb (
        .clk     (clk),
        .rst     (rst),
        .capture (rd_rise),
        .sel     (sel),
        .ctrl    (ctrl),
        .flags   (flags),
        .req     (req),
        .rd_q    (rd_data)
    );

    // R1: low nibble of a captured status byte is zero
    a_r1_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && sel == SEL_STAT) |=> (rd_data[3:0] == 4'h0));

    // R9: valid-data byte is constant
    a_r9_valid_const: assert property (@(posedge clk) disable iff (rst)
        (rd_rise && sel == SEL_VALID) |=> (rd_data == VALID_BYTE));

    // R2: the request needs a set flag behind it
    a_r2_req_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_oe |-> (|flags));

    // R7: enabling an already pending source raises the request
    a_r7_late_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && !wr_data[7] && |(wr_data[6:4] & flags) && !end_read)
        |=> irq_oe);
endmodule

// File: tb/tb_irq_status_regs.sv
module tb_irq_status_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       ev_periodic = 1'b0;
    logic       ev_alarm = 1'b0;
    logic       ev_update = 1'b0;
    logic       irq_oe;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    // scoreboard queues: kind 0 = read data, kind 1 = request line
    bit         q_kind[$];
    logic [7:0] q_exp[$];
    string      q_req[$];

    localparam logic [1:0] S_CTRL = 2'd0, S_STAT = 2'd1, S_VALID = 2'd2, S_NONE = 2'd3;

    always #2 clk = ~clk;

    irq_status_regs dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .ev_periodic(ev_periodic),
        .ev_alarm(ev_alarm), .ev_update(ev_update), .irq_oe(irq_oe)
    );

    task automatic push(input bit kind, input logic [7:0] exp, input string req);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_req.push_back(req);
    endtask

    // monitor: compare pending expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q_kind.size() > 0) begin
                automatic bit         k = q_kind.pop_front();
                automatic logic [7:0] e = q_exp.pop_front();
                automatic string      r = q_req.pop_front();
                automatic logic [7:0] a = k ? {7'd0, irq_oe} : rd_data;
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s %s actual=%02h expected=%02h",
                             r, k ? "irq_oe" : "rd_data", a, e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] pau);
        @(negedge clk);
        {ev_periodic, ev_alarm, ev_update} = pau;
        @(negedge clk);
        {ev_periodic, ev_alarm, ev_update} = 3'b000;
    endtask

    // events given as {periodic, alarm, update}: on first, middle and ending cycle
    task automatic rd(input logic [1:0] s, input logic [7:0] exp, input string req,
                      input logic [2:0] ev_s, input logic [2:0] ev_m, input logic [2:0] ev_e);
        @(negedge clk);
        reg_sel = s; rd_stb = 1'b1;
        {ev_periodic, ev_alarm, ev_update} = ev_s;
        @(negedge clk);
        push(1'b0, exp, req);
        {ev_periodic, ev_alarm, ev_update} = ev_m;
        @(negedge clk);
        {ev_periodic, ev_alarm, ev_update} = 3'b000;
        @(negedge clk);
        rd_stb = 1'b0;
        {ev_periodic, ev_alarm, ev_update} = ev_e;
        @(negedge clk);
        {ev_periodic, ev_alarm, ev_update} = 3'b000;
    endtask

    task automatic chk_irq(input logic e, input string req);
        push(1'b1, {7'd0, e}, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=hung expected=done");
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        chk_irq(1'b0, "R10");
        rd(S_CTRL, 8'h00, "R10", 3'b000, 3'b000, 3'b000);
        rd(S_STAT, 8'h00, "R10", 3'b000, 3'b000, 3'b000);
        rd(S_VALID, 8'h80, "R9", 3'b000, 3'b000, 3'b000);

        // R3 control readback
        wr(S_CTRL, 8'h0E);
        rd(S_CTRL, 8'h0E, "R3", 3'b000, 3'b000, 3'b000);
        chk_irq(1'b0, "R2");

        // R4 flag set with enable off; R1 layout; R5 clear on read
        pulse(3'b100);
        chk_irq(1'b0, "R4");
        rd(S_STAT, 8'h40, "R4", 3'b000, 3'b000, 3'b000);
        rd(S_STAT, 8'h00, "R5", 3'b000, 3'b000, 3'b000);

        // R7 late enable of a pending alarm
        pulse(3'b010);
        chk_irq(1'b0, "R4");
        wr(S_CTRL, 8'h2E);
        chk_irq(1'b1, "R7");
        rd(S_STAT, 8'hA0, "R1", 3'b000, 3'b000, 3'b000);
        chk_irq(1'b0, "R5");

        // R2 all enables; R6 event in the middle of a read
        wr(S_CTRL, 8'h7E);
        pulse(3'b001);
        chk_irq(1'b1, "R2");
        rd(S_STAT, 8'h90, "R5", 3'b000, 3'b010, 3'b000);
        chk_irq(1'b1, "R6");
        rd(S_STAT, 8'hA0, "R6", 3'b000, 3'b000, 3'b000);
        chk_irq(1'b0, "R5");

        // R6 event on the first read cycle is not in the snapshot but is kept
        rd(S_STAT, 8'h00, "R5", 3'b100, 3'b000, 3'b000);
        chk_irq(1'b1, "R6");
        rd(S_STAT, 8'hC0, "R6", 3'b000, 3'b000, 3'b000);

        // R6 event on the ending cycle
        rd(S_STAT, 8'h00, "R5", 3'b000, 3'b000, 3'b010);
        chk_irq(1'b1, "R6");
        rd(S_STAT, 8'hA0, "R6", 3'b000, 3'b000, 3'b000);

        // R8 freeze clears update enable
        wr(S_CTRL, 8'hFE);
        rd(S_CTRL, 8'hEE, "R8", 3'b000, 3'b000, 3'b000);
        wr(S_CTRL, 8'h10);
        rd(S_CTRL, 8'h10, "R8", 3'b000, 3'b000, 3'b000);

        // R9 ignored writes
        pulse(3'b001);
        wr(S_STAT, 8'h0F);
        wr(S_VALID, 8'h00);
        wr(S_NONE, 8'hFF);
        rd(S_VALID, 8'h80, "R9", 3'b000, 3'b000, 3'b000);
        rd(S_NONE, 8'h00, "R9", 3'b000, 3'b000, 3'b000);
        rd(S_CTRL, 8'h10, "R9", 3'b000, 3'b000, 3'b000);
        rd(S_STAT, 8'h90, "R9", 3'b000, 3'b000, 3'b000);

        // R7 enable written after a pending update flag
        wr(S_CTRL, 8'h00);
        pulse(3'b001);
        chk_irq(1'b0, "R2");
        wr(S_CTRL, 8'h10);
        chk_irq(1'b1, "R7");
        rd(S_STAT, 8'h90, "R1", 3'b000, 3'b000, 3'b000);

        // R2 two sources, only one enabled
        pulse(3'b110);
        chk_irq(1'b0, "R2");
        rd(S_STAT, 8'h60, "R2", 3'b000, 3'b000, 3'b000);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule